// File: doc/BRIEF.md
# Seconds Countdown Alarm with Wake Output

This block is a relative alarm driven by a one-second tick. A host loads a 32-bit number of seconds through a small register interface and turns the counter on. From then on, each tick lowers the remaining value by one. When the value runs out, a sticky pending flag is raised. The pending flag is gated by an interrupt-enable bit to drive an interrupt line. It is gated separately by a wake-enable bit to drive a wake output that can bring the system out of a low-power state. The host can read the remaining value at any time. It clears the pending flag by writing a 1 to it.

The expected software sequence to re-arm the alarm is: turn the alarm off, write zero to the load register, wait, then write the new count. Loading zero therefore parks the counter at zero and never raises the flag. A second alarm of the week type exists only as registers: its enable and interrupt-enable bits can be written and read back. Its pending bit clears on a write of 1 but nothing in this block ever sets it.

The register interface is a single-cycle write strobe with a combinational read port. Every register resets to zero on a synchronous, active-high reset.

Top module: `countdown_alarm`

## Requirements
- R1: After reset, every register reads zero, and `irq` and `wake` are low.
- R2: A write to offset 0x20 copies the written value into the remaining counter on the same clock edge. From the next cycle, offset 0x24 reads the new remaining value and offset 0x20 reads back the loaded value.
- R3: On a clock edge with `sec_tick` high, counter enable (offset 0x28 bit 0) set and remaining value nonzero, the remaining value drops by one. Without a tick, or with the enable clear, the remaining value does not change.
- R4: A remaining value of zero stays at zero on later ticks and never raises pending. Loading zero therefore stops the countdown cleanly.
- R5: The pending flag (offset 0x30 bit 0) is set on the counting tick that takes the remaining value from 1 to 0. Once set, it stays set until cleared.
- R6: Writing offset 0x30 with bit 0 set clears pending. Writing it with bit 0 clear leaves pending unchanged.
- R7: `irq` is high exactly when pending is set and interrupt enable (offset 0x2C bit 0) is set.
- R8: `wake` is high exactly when pending is set and wake enable (offset 0x50 bit 0) is set.
- R9: The week-alarm enable (0x44 bit 0) and interrupt enable (0x48 bit 0) store bit 0 and read it back. The week pending bit (0x4C bit 0) reads zero, accepts a write-1 clear, and never sets. None of these three registers affects `irq` or `wake`.
- R10: A load write takes priority over a tick in the same cycle. An expiry takes priority over a pending clear in the same cycle, so the flag stays set.
- R11: Enable registers hold only bit 0, and other bits read zero. A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wake request |

## Verification
The assertions assume that `sec_tick` and `bus_wr` are clean synchronous signals. They also assume that only one register write happens per cycle, which is inherent to the single-strobe interface. The assertions make no assumption about tick spacing, so the stimulus is allowed to tick on consecutive cycles and to collide ticks with loads and clears on purpose. The random phase keeps load values small so that expiries happen often within the run. Each bus write is held for exactly one cycle at the falling edge, so every write lands on a single rising edge.

// File: rtl/calarm_pkg.sv
package calarm_pkg;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_LOAD    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_REMAIN  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CNT_EN  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_WK_EN   = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_WK_IE   = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_WK_PEND = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_WAKE_EN = 8'h50;

    typedef struct packed {
        logic load;
        logic cnt_en;
        logic irq_en;
        logic pend_w1c;
        logic wk_en;
        logic wk_ie;
        logic wk_w1c;
        logic wake_en;
    } wr_strobe_t;

    typedef struct packed {
        logic cnt_en;
        logic irq_en;
        logic wake_en;
    } ctrl_t;

    function automatic logic wr_hit(input logic wr,
                                    input logic [ADDR_W-1:0] addr,
                                    input logic [ADDR_W-1:0] ofs);
        return wr && (addr == ofs);
    endfunction

endpackage

// File: rtl/calarm_regfile.sv
module calarm_regfile
    import calarm_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output wr_strobe_t        strobe,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load_q
);

    always_comb begin
        strobe.load     = wr_hit(bus_wr, bus_addr, OFS_LOAD);
        strobe.cnt_en   = wr_hit(bus_wr, bus_addr, OFS_CNT_EN);
        strobe.irq_en   = wr_hit(bus_wr, bus_addr, OFS_IRQ_EN);
        strobe.pend_w1c = wr_hit(bus_wr, bus_addr, OFS_PEND) && bus_wdata[0];
        strobe.wk_en    = wr_hit(bus_wr, bus_addr, OFS_WK_EN);
        strobe.wk_ie    = wr_hit(bus_wr, bus_addr, OFS_WK_IE);
        strobe.wk_w1c   = wr_hit(bus_wr, bus_addr, OFS_WK_PEND) && bus_wdata[0];
        strobe.wake_en  = wr_hit(bus_wr, bus_addr, OFS_WAKE_EN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            load_q <= '0;
        end else begin
            if (strobe.load)    load_q       <= bus_wdata[CNT_W-1:0];
            if (strobe.cnt_en)  ctrl.cnt_en  <= bus_wdata[0];
            if (strobe.irq_en)  ctrl.irq_en  <= bus_wdata[0];
            if (strobe.wake_en) ctrl.wake_en <= bus_wdata[0];
        end
    end

    // R2: the load register holds what was written
    a_r2_load_kept: assert property (@(posedge clk) disable iff (rst)
        strobe.load |=> load_q == $past(bus_wdata[CNT_W-1:0]));

endmodule

// File: rtl/calarm_countdown.sv
module calarm_countdown #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_tick,
    input  logic             cnt_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             pend_w1c,
    output logic [CNT_W-1:0] remain,
    output logic             pend
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;
    logic expire;

    assign step   = sec_tick && cnt_en && (remain != '0) && !load_stb;
    assign expire = step && (remain == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            pend   <= 1'b0;
        end else begin
            if (load_stb)
                remain <= load_val;
            else if (step)
                remain <= remain - ONE;

            if (expire)
                pend <= 1'b1;
            else if (pend_w1c)
                pend <= 1'b0;
        end
    end

    // R3: a counting tick lowers the value by exactly one
    a_r3_tick_dec: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && cnt_en && !load_stb && remain != '0)
        |=> remain == $past(remain) - ONE);

    // R3: no tick and no load, no change
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !load_stb) |=> $stable(remain));

    // R4: zero is a resting state without a load
    a_r4_zero_parks: assert property (@(posedge clk) disable iff (rst)
        (remain == '0 && !load_stb) |=> (remain == '0));

    // R5: reaching zero from one raises pending
    a_r5_expire_sets: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && cnt_en && !load_stb && remain == ONE) |=> pend);

    // R5 / R6: pending is sticky unless cleared
    a_r6_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend && !pend_w1c) |=> pend);

    // R10: load beats a concurrent tick
    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> remain == $past(load_val));

endmodule

// File: rtl/calarm_week.sv
module calarm_week (
    input  logic clk,
    input  logic rst,
    input  logic en_wr,
    input  logic ie_wr,
    input  logic pend_w1c,
    input  logic wdata0,
    output logic wk_en,
    output logic wk_ie,
    output logic wk_pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wk_en   <= 1'b0;
            wk_ie   <= 1'b0;
            wk_pend <= 1'b0;
        end else begin
            if (en_wr)    wk_en   <= wdata0;
            if (ie_wr)    wk_ie   <= wdata0;
            if (pend_w1c) wk_pend <= 1'b0;
        end
    end

    // R9: the week pending bit never rises
    a_r9_week_quiet: assert property (@(posedge clk) disable iff (rst)
        !wk_pend |=> !wk_pend);

endmodule

// File: rtl/countdown_alarm.sv
module countdown_alarm
    import calarm_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wake
);

    localparam logic [DATA_W-1:0] ZERO = '0;

    wr_strobe_t       strobe;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] remain;
    logic             pend;
    logic             wk_en;
    logic             wk_ie;
    logic             wk_pend;

    calarm_regfile #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .strobe    (strobe),
        .ctrl      (ctrl),
        .load_q    (load_q)
    );

    calarm_countdown #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .cnt_en   (ctrl.cnt_en),
        .load_stb (strobe.load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .pend_w1c (strobe.pend_w1c),
        .remain   (remain),
        .pend     (pend)
    );

    calarm_week u_week (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (strobe.wk_en),
        .ie_wr    (strobe.wk_ie),
        .pend_w1c (strobe.wk_w1c),
        .wdata0   (bus_wdata[0]),
        .wk_en    (wk_en),
        .wk_ie    (wk_ie),
        .wk_pend  (wk_pend)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_LOAD:    bus_rdata = DATA_W'(load_q);
            OFS_REMAIN:  bus_rdata = DATA_W'(remain);
            OFS_CNT_EN:  bus_rdata = {ZERO[DATA_W-1:1], ctrl.cnt_en};
            OFS_IRQ_EN:  bus_rdata = {ZERO[DATA_W-1:1], ctrl.irq_en};
            OFS_PEND:    bus_rdata = {ZERO[DATA_W-1:1], pend};
            OFS_WK_EN:   bus_rdata = {ZERO[DATA_W-1:1], wk_en};
            OFS_WK_IE:   bus_rdata = {ZERO[DATA_W-1:1], wk_ie};
            OFS_WK_PEND: bus_rdata = {ZERO[DATA_W-1:1], wk_pend};
            OFS_WAKE_EN: bus_rdata = {ZERO[DATA_W-1:1], ctrl.wake_en};
            default:     bus_rdata = ZERO;
        endcase
    end

    assign irq  = pend && ctrl.irq_en;
    assign wake = pend && ctrl.wake_en;

    // R7: an interrupt rises only from a newly set or already set flag
    a_r7_irq_source: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (pend && ctrl.irq_en));

    // R8: wake falls when pending is cleared
    a_r8_wake_drops: assert property (@(posedge clk) disable iff (rst)
        (wake && strobe.pend_w1c && !(sec_tick && ctrl.cnt_en && remain == CNT_W'(1) && !strobe.load))
        |=> !wake);

endmodule

// File: tb/countdown_alarm_tb.sv
module countdown_alarm_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        sec_tick;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wake;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    // reference model state
    logic [31:0] m_load, m_rem;
    bit          m_cen, m_ien, m_wen, m_pend, m_wke, m_wki;

    countdown_alarm u_dut (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .wake      (wake)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h20: return m_load;
            8'h24: return m_rem;
            8'h28: return {31'd0, m_cen};
            8'h2C: return {31'd0, m_ien};
            8'h30: return {31'd0, m_pend};
            8'h44: return {31'd0, m_wke};
            8'h48: return {31'd0, m_wki};
            8'h50: return {31'd0, m_wen};
            default: return 32'd0;
        endcase
    endfunction

    // behavioural model, updated on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_load = 0; m_rem = 0; m_cen = 0; m_ien = 0; m_wen = 0;
            m_pend = 0; m_wke = 0; m_wki = 0;
        end else begin
            bit ld, fire;
            ld   = bus_wr && bus_addr == 8'h20;
            fire = !ld && sec_tick && m_cen && m_rem == 1;
            if (ld) begin
                m_load = bus_wdata;
                m_rem  = bus_wdata;
            end else if (sec_tick && m_cen && m_rem != 0) begin
                m_rem = m_rem - 1;
            end
            if (fire) m_pend = 1;
            else if (bus_wr && bus_addr == 8'h30 && bus_wdata[0]) m_pend = 0;
            if (bus_wr && bus_addr == 8'h28) m_cen = bus_wdata[0];
            if (bus_wr && bus_addr == 8'h2C) m_ien = bus_wdata[0];
            if (bus_wr && bus_addr == 8'h50) m_wen = bus_wdata[0];
            if (bus_wr && bus_addr == 8'h44) m_wke = bus_wdata[0];
            if (bus_wr && bus_addr == 8'h48) m_wki = bus_wdata[0];
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (!rst && !done) begin
            check(cur_req, "rdata", bus_rdata, m_read(bus_addr));
            check("R7", "irq", {31'd0, irq}, {31'd0, m_pend && m_ien});
            check("R8", "wake", {31'd0, wake}, {31'd0, m_pend && m_wen});
        end
    end

    task automatic step(input logic w, input logic [7:0] a,
                        input logic [31:0] d, input logic t);
        bus_wr = w; bus_addr = a; bus_wdata = d; sec_tick = t;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 8'h24, 32'd0, 1'b1);
            step(1'b0, 8'h24, 32'd0, 1'b0);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        bus_wr = 0; sec_tick = 0; bus_addr = a;
        #1;
        check(req, $sformatf("read %h", a), bus_rdata, exp);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; sec_tick = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        cur_req = "R1";
        foreach (u_offs[i]) rd(u_offs[i], 32'd0, "R1");
        check("R1", "irq", {31'd0, irq}, 32'd0);
        check("R1", "wake", {31'd0, wake}, 32'd0);

        // R2: load
        cur_req = "R2";
        wr(8'h20, 32'd5);
        rd(8'h24, 32'd5, "R2");
        rd(8'h20, 32'd5, "R2");

        // R3: disabled counter ignores ticks, enabled one counts
        cur_req = "R3";
        ticks(3);
        rd(8'h24, 32'd5, "R3");
        wr(8'h28, 32'd1);
        ticks(2);
        rd(8'h24, 32'd3, "R3");
        repeat (4) step(1'b0, 8'h24, 32'd0, 1'b0);
        rd(8'h24, 32'd3, "R3");

        // R5 / R7 / R8: expiry
        cur_req = "R5";
        wr(8'h2C, 32'd1);
        wr(8'h50, 32'd1);
        ticks(2);
        rd(8'h30, 32'd0, "R5");
        ticks(1);
        rd(8'h30, 32'd1, "R5");
        check("R7", "irq after expiry", {31'd0, irq}, 32'd1);
        check("R8", "wake after expiry", {31'd0, wake}, 32'd1);
        ticks(3);
        rd(8'h24, 32'd0, "R4");
        rd(8'h30, 32'd1, "R5");

        // R7 / R8: gating by each enable
        cur_req = "R7";
        wr(8'h2C, 32'd0);
        check("R7", "irq gated", {31'd0, irq}, 32'd0);
        check("R8", "wake stays", {31'd0, wake}, 32'd1);
        wr(8'h50, 32'd0);
        check("R8", "wake gated", {31'd0, wake}, 32'd0);
        wr(8'h2C, 32'd1);
        wr(8'h50, 32'd1);

        // R6: write 0 keeps, write 1 clears
        cur_req = "R6";
        wr(8'h30, 32'hFFFF_FFFE);
        rd(8'h30, 32'd1, "R6");
        wr(8'h30, 32'd1);
        rd(8'h30, 32'd0, "R6");
        check("R6", "irq after clear", {31'd0, irq}, 32'd0);

        // R4: re-arm sequence with a zero load
        cur_req = "R4";
        wr(8'h28, 32'd0);
        wr(8'h20, 32'd0);
        wr(8'h28, 32'd1);
        ticks(4);
        rd(8'h24, 32'd0, "R4");
        rd(8'h30, 32'd0, "R4");

        // R10: load beats tick; expiry beats clear
        cur_req = "R10";
        wr(8'h20, 32'd9);
        step(1'b1, 8'h20, 32'd7, 1'b1);
        rd(8'h24, 32'd7, "R10");
        wr(8'h20, 32'd1);
        step(1'b1, 8'h30, 32'd1, 1'b1);
        rd(8'h30, 32'd1, "R10");
        rd(8'h24, 32'd0, "R10");
        wr(8'h30, 32'd1);

        // R9: week registers
        cur_req = "R9";
        wr(8'h44, 32'd1);
        wr(8'h48, 32'd3);
        rd(8'h44, 32'd1, "R9");
        rd(8'h48, 32'd1, "R9");
        wr(8'h4C, 32'd1);
        rd(8'h4C, 32'd0, "R9");
        check("R9", "irq unaffected", {31'd0, irq}, 32'd0);
        check("R9", "wake unaffected", {31'd0, wake}, 32'd0);

        // R11: only bit 0 stored, unmapped reads zero
        cur_req = "R11";
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, 32'd1, "R11");
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h3C, 32'd0, "R11");

        // R3: wide value, no wrap across the top bits
        cur_req = "R3";
        wr(8'h20, 32'hFFFF_FFFF);
        ticks(3);
        rd(8'h24, 32'hFFFF_FFFC, "R3");

        // mixed random traffic against the model
        cur_req = "R10";
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            a = u_offs[$urandom % 10];
            d = (a == 8'h20) ? ($urandom % 6) : $urandom;
            step(($urandom % 3) == 0, a, d, ($urandom % 2) == 1);
        end
        step(1'b0, 8'h24, 32'd0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    logic [7:0] u_offs [10] = '{8'h20, 8'h24, 8'h28, 8'h2C, 8'h30,
                                8'h44, 8'h48, 8'h4C, 8'h50, 8'h00};

endmodule